// File: doc/BRIEF.md
# Per-Core Read Issue Slot Manager

This block sits between the request sources of a small processor cluster and a single AXI-style read address channel. Each core (one to four, set by a parameter) presents read-class requests tagged with a category code. An optional coherency port adds a fifth source that issues only linefills. The block admits a request only if the core has room in its eight-slot budget and in the per-category sub-limit. It then gives the request a 6-bit read ID that names its source and slot, and presents it on the address channel. The ID stays in use until the matching completion comes back.

Sources are served in round-robin order. A two-part DVM message goes out as two consecutive address transactions that carry the same ID. That ID is released only after both completions are seen. Each core may also have at most one exclusive read outstanding at a time. Every ID the block hands out is unique among the outstanding reads. Completions that name a free slot or an absent source change nothing.

Top module: `rim_read_issue_mgr`

## Requirements
- R1: After reset no read is outstanding. While no request is valid, `ar_valid_o` and every ready output stay low.
- R2: A core never holds more than 8 outstanding reads. A request from a core that already holds 8 is not accepted.
- R3: The category code selects a per-core cap on outstanding reads of that category: 0 data linefill 8, 1 non-cacheable/Device read 4, 2 page-walk read 1, 3 instruction linefill 3, 4 coherency operation 5, 5 DVM message 8. Codes 6 and 7 are never accepted.
- R4: A core read carries the ID {1'b0, core[1:0], slot[2:0]}. A coherency-port read carries {1'b1, 3'b000, slot[1:0]}. The slot is the lowest-numbered free slot of that source.
- R5: The coherency port holds at most 4 outstanding reads. Its reads go out with category code 0.
- R6: Source order is cores 0 to N-1 and then the port. When no second DVM part is pending, the first eligible source at or after the round-robin pointer is presented. After a handshake the pointer moves to the source just after the winner.
- R7: A source's ready output is high only in a cycle where it is the presented source and `ar_ready_i` is high. At most one ready is high in any cycle.
- R8: A core request with category 5 and `core_req_two_i` set is a two-part DVM. After its accepted handshake, the next address transaction is its second part: `ar_second_o` is high, `ar_cat_o` is 5 and the ID is the same. No request is accepted until that second handshake.
- R9: The slot of a two-part DVM is freed only when a second completion for its ID has been received.
- R10: A completion (`rc_valid_i`) for an outstanding ID frees its slot from the next cycle on. A completion whose ID names a free slot or an absent source is ignored.
- R11: A core request with `core_req_excl_i` set is not accepted while that core already has an exclusive read outstanding. Non-exclusive requests from that core are unaffected.
- R12: The block never issues an ID whose core field is not below NUM_CORES. It never issues an ID with bit 5 set when the port is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_valid_i | input | NUM_CORES | Request valid per core |
| core_req_cat_i | input | 3*NUM_CORES | Category code per core, core c at bits [3c+2:3c] |
| core_req_two_i | input | NUM_CORES | Two-part DVM flag per core |
| core_req_excl_i | input | NUM_CORES | Exclusive read flag per core |
| core_req_ready_o | output | NUM_CORES | Request accepted, per core |
| port_req_valid_i | input | 1 | Coherency port linefill request valid |
| port_req_ready_o | output | 1 | Coherency port request accepted |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_id_o | output | 6 | Read ID |
| ar_cat_o | output | 3 | Category of the presented read |
| ar_second_o | output | 1 | Presented read is the second part of a DVM |
| rc_valid_i | input | 1 | Read completion valid |
| rc_id_i | input | 6 | ID of the completed read |

## Verification
The bench builds the block with four cores and the coherency port present, so there are five sources. With that setup the core field reaches its top value 3, port IDs with bit 5 set are issued, and the round-robin pointer has to wrap from the port back to core 0. The directed phases fill one core to its total budget and push each category code to its cap, including the invalid codes. They also fill the four port slots, stall two-part DVMs with ready held low, and send completions for free and absent IDs. A long mixed phase then checks uniqueness and lowest-free-slot reuse under random ready and completion timing.

// File: rtl/rim_pkg.sv
package rim_pkg;
  localparam int CAT_W      = 3;
  localparam int ID_W       = 6;
  localparam int CORE_SLOTS = 8;
  localparam int PORT_SLOTS = 4;
  localparam int CORE_SEL_W = 2;

  typedef enum logic [CAT_W-1:0] {
    CAT_LINEFILL = 3'd0,
    CAT_NC       = 3'd1,
    CAT_WALK     = 3'd2,
    CAT_IFILL    = 3'd3,
    CAT_COH      = 3'd4,
    CAT_DVM      = 3'd5
  } cat_e;

  function automatic int cat_limit(logic [CAT_W-1:0] c);
    case (c)
      3'd0:    return 8;
      3'd1:    return 4;
      3'd2:    return 1;
      3'd3:    return 3;
      3'd4:    return 5;
      3'd5:    return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rim_slot_table.sv
module rim_slot_table
  import rim_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter bit CHECK_CAT = 1'b1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CAT_W-1:0] req_cat_i,
  input  logic             req_excl_i,
  output logic             can_admit_o,
  output logic [IDX_W-1:0] free_idx_o,
  input  logic             alloc_i,
  input  logic             alloc_two_i,
  input  logic [CAT_W-1:0] alloc_cat_i,
  input  logic             alloc_excl_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] done_idx_i
);
  logic [DEPTH-1:0] vld_q, two_q, ex_q;
  logic [CAT_W-1:0] cat_q [DEPTH];

  logic [CNT_W-1:0] total, same;
  logic             ex_any, found, cat_ok, excl_ok;

  always_comb begin
    total      = '0;
    same       = '0;
    ex_any     = 1'b0;
    found      = 1'b0;
    free_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i]) begin
        total = total + 1'b1;
        if (cat_q[i] == req_cat_i) same = same + 1'b1;
        if (ex_q[i]) ex_any = 1'b1;
      end else if (!found) begin
        found      = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end

  assign cat_ok  = !CHECK_CAT ||
                   ((req_cat_i <= CAT_DVM) && (int'(same) < cat_limit(req_cat_i)));
  assign excl_ok = !CHECK_CAT || !req_excl_i || !ex_any;
  assign can_admit_o = (int'(total) < DEPTH) && cat_ok && excl_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      two_q <= '0;
      ex_q  <= '0;
      for (int i = 0; i < DEPTH; i++) cat_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_i && free_idx_o == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          two_q[i] <= alloc_two_i;
          ex_q[i]  <= alloc_excl_i;
          cat_q[i] <= alloc_cat_i;
        end else if (done_i && done_idx_i == IDX_W'(i) && vld_q[i]) begin
          // two-part entries need a second completion
          if (two_q[i]) begin
            two_q[i] <= 1'b0;
          end else begin
            vld_q[i] <= 1'b0;
            ex_q[i]  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rim_rr_arb.sv
module rim_rr_arb #(
  parameter int N      = 5,
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic [N-1:0]     gnt_o,
  output logic             any_o
);
  logic [PTR_W-1:0] ptr_q, win;

  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(ptr_q) + i;
      if (j >= N) j = j - N;
      if (!any_o && req_i[j]) begin
        any_o    = 1'b1;
        gnt_o[j] = 1'b1;
        win      = PTR_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/rim_read_issue_mgr.sv
module rim_read_issue_mgr
  import rim_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter bit HAS_PORT  = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES-1:0]       core_req_valid_i,
  input  logic [NUM_CORES*CAT_W-1:0] core_req_cat_i,
  input  logic [NUM_CORES-1:0]       core_req_two_i,
  input  logic [NUM_CORES-1:0]       core_req_excl_i,
  output logic [NUM_CORES-1:0]       core_req_ready_o,
  input  logic                       port_req_valid_i,
  output logic                       port_req_ready_o,
  output logic                       ar_valid_o,
  input  logic                       ar_ready_i,
  output logic [ID_W-1:0]            ar_id_o,
  output logic [CAT_W-1:0]           ar_cat_o,
  output logic                       ar_second_o,
  input  logic                       rc_valid_i,
  input  logic [ID_W-1:0]            rc_id_i
);
  localparam int N_SRC   = NUM_CORES + (HAS_PORT ? 1 : 0);
  localparam int CIDX_W  = $clog2(CORE_SLOTS);
  localparam int PIDX_W  = $clog2(PORT_SLOTS);

  logic [N_SRC-1:0] src_elig, src_gnt, src_two;
  logic [ID_W-1:0]  src_id  [N_SRC];
  logic [CAT_W-1:0] src_cat [N_SRC];
  logic             any_elig, issue_new;
  logic             lock_q;
  logic [ID_W-1:0]  lock_id_q;
  logic [ID_W-1:0]  win_id;
  logic [CAT_W-1:0] win_cat;
  logic             win_two;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CIDX_W-1:0] fidx;
    logic              adm, done;
    logic [CAT_W-1:0]  cat;

    assign cat  = core_req_cat_i[c*CAT_W +: CAT_W];
    assign done = rc_valid_i && !rc_id_i[ID_W-1] &&
                  (rc_id_i[ID_W-2 -: CORE_SEL_W] == CORE_SEL_W'(c));

    rim_slot_table #(.DEPTH(CORE_SLOTS), .CHECK_CAT(1'b1)) u_slots (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_cat_i    (cat),
      .req_excl_i   (core_req_excl_i[c]),
      .can_admit_o  (adm),
      .free_idx_o   (fidx),
      .alloc_i      (issue_new && src_gnt[c]),
      .alloc_two_i  (src_two[c]),
      .alloc_cat_i  (cat),
      .alloc_excl_i (core_req_excl_i[c]),
      .done_i       (done),
      .done_idx_i   (rc_id_i[CIDX_W-1:0])
    );

    assign src_elig[c]      = core_req_valid_i[c] && adm;
    assign src_two[c]       = core_req_two_i[c] && (cat == CAT_DVM);
    assign src_id[c]        = {1'b0, CORE_SEL_W'(c), fidx};
    assign src_cat[c]       = cat;
    assign core_req_ready_o[c] = issue_new && src_gnt[c];
  end

  if (HAS_PORT) begin : g_port
    logic [PIDX_W-1:0] fidx;
    logic              adm, done;

    assign done = rc_valid_i && rc_id_i[ID_W-1] &&
                  (rc_id_i[ID_W-2:PIDX_W] == '0);

    rim_slot_table #(.DEPTH(PORT_SLOTS), .CHECK_CAT(1'b0)) u_slots (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_cat_i    (CAT_LINEFILL),
      .req_excl_i   (1'b0),
      .can_admit_o  (adm),
      .free_idx_o   (fidx),
      .alloc_i      (issue_new && src_gnt[NUM_CORES]),
      .alloc_two_i  (1'b0),
      .alloc_cat_i  (CAT_LINEFILL),
      .alloc_excl_i (1'b0),
      .done_i       (done),
      .done_idx_i   (rc_id_i[PIDX_W-1:0])
    );

    assign src_elig[NUM_CORES] = port_req_valid_i && adm;
    assign src_two[NUM_CORES]  = 1'b0;
    assign src_id[NUM_CORES]   = {1'b1, (ID_W-1-PIDX_W)'(0), fidx};
    assign src_cat[NUM_CORES]  = CAT_LINEFILL;
    assign port_req_ready_o    = issue_new && src_gnt[NUM_CORES];
  end else begin : g_no_port
    assign port_req_ready_o = 1'b0;
  end

  rim_rr_arb #(.N(N_SRC)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (src_elig & {N_SRC{!lock_q}}),
    .adv_i  (issue_new),
    .gnt_o  (src_gnt),
    .any_o  (any_elig)
  );

  always_comb begin
    win_id  = '0;
    win_cat = '0;
    win_two = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_gnt[s]) begin
        win_id  = win_id  | src_id[s];
        win_cat = win_cat | src_cat[s];
        win_two = win_two | src_two[s];
      end
    end
  end

  assign issue_new   = !lock_q && any_elig && ar_ready_i;
  assign ar_valid_o  = lock_q || any_elig;
  assign ar_id_o     = lock_q ? lock_id_q : win_id;
  assign ar_cat_o    = lock_q ? CAT_DVM : win_cat;
  assign ar_second_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
    end else if (lock_q) begin
      if (ar_ready_i) lock_q <= 1'b0;
    end else if (issue_new && win_two) begin
      lock_q    <= 1'b1;
      lock_id_q <= win_id;
    end
  end
endmodule

// File: rtl/rim_read_issue_mgr_chk.sv
module rim_read_issue_mgr_chk
  import rim_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter bit HAS_PORT  = 1'b1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CORES*CAT_W-1:0] core_req_cat_i,
  input logic [NUM_CORES-1:0]       core_req_two_i,
  input logic [NUM_CORES-1:0]       core_req_ready_o,
  input logic                       port_req_ready_o,
  input logic                       ar_valid_o,
  input logic                       ar_ready_i,
  input logic [ID_W-1:0]            ar_id_o,
  input logic [CAT_W-1:0]           ar_cat_o,
  input logic                       ar_second_o
);
  p_ready_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({port_req_ready_o, core_req_ready_o}));

  p_ready_hs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{port_req_ready_o, core_req_ready_o}) |-> (ar_valid_o && ar_ready_i));

  p_no_accept_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_second_o |-> !(|{port_req_ready_o, core_req_ready_o}));

  p_second_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ar_second_o && !ar_ready_i) |=> (ar_second_o && $stable(ar_id_o)));

  p_absent_id_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> (ar_id_o[ID_W-1] ? (HAS_PORT && ar_id_o[ID_W-2:2] == '0)
                                    : (int'(ar_id_o[ID_W-2 -: CORE_SEL_W]) < NUM_CORES)));

  p_port_cat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_req_ready_o |-> (ar_cat_o == CAT_LINEFILL && ar_id_o[ID_W-1]));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    p_bad_cat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_req_ready_o[c] |-> (core_req_cat_i[c*CAT_W +: CAT_W] <= CAT_DVM));

    p_dvm_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_req_ready_o[c] && core_req_two_i[c] &&
       core_req_cat_i[c*CAT_W +: CAT_W] == CAT_DVM)
      |=> (ar_valid_o && ar_second_o && ar_id_o == $past(ar_id_o)));
  end
endmodule

bind rim_read_issue_mgr rim_read_issue_mgr_chk #(
  .NUM_CORES (NUM_CORES),
  .HAS_PORT  (HAS_PORT)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .core_req_cat_i   (core_req_cat_i),
  .core_req_two_i   (core_req_two_i),
  .core_req_ready_o (core_req_ready_o),
  .port_req_ready_o (port_req_ready_o),
  .ar_valid_o       (ar_valid_o),
  .ar_ready_i       (ar_ready_i),
  .ar_id_o          (ar_id_o),
  .ar_cat_o         (ar_cat_o),
  .ar_second_o      (ar_second_o)
);

// File: tb/rim_read_issue_mgr_tb_top.sv
`timescale 1ns/1ps
module rim_read_issue_mgr_tb_top;
  localparam int NC = 4;
  localparam bit HP = 1'b1;
  localparam int NS = NC + (HP ? 1 : 0);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NC-1:0]   cv = '0, ctwo = '0, cex = '0;
  logic [NC*3-1:0] ccat = '0;
  logic [NC-1:0]   crdy;
  logic            pv = 1'b0, prdy;
  logic            arv, arr = 1'b0, arsec;
  logic [5:0]      arid;
  logic [2:0]      arcat;
  logic            rcv = 1'b0;
  logic [5:0]      rcid = '0;

  always #2.5 clk_i = ~clk_i;

  rim_read_issue_mgr #(.NUM_CORES(NC), .HAS_PORT(HP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .core_req_valid_i(cv), .core_req_cat_i(ccat), .core_req_two_i(ctwo),
    .core_req_excl_i(cex), .core_req_ready_o(crdy),
    .port_req_valid_i(pv), .port_req_ready_o(prdy),
    .ar_valid_o(arv), .ar_ready_i(arr), .ar_id_o(arid), .ar_cat_o(arcat),
    .ar_second_o(arsec), .rc_valid_i(rcv), .rc_id_i(rcid));

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // reference state: remaining completions per slot (0 = free)
  int rem [NS][8];
  int mcat[NS][8];
  bit mex [NS][8];
  int ptr = 0;
  bit lock = 0;
  logic [5:0] lock_id = '0;

  // stimulus knobs
  logic [NS-1:0] kmask = '0;
  int kreq = 80, kcat = -1, ktwo = 0, kex = 0, krdy = 100, krc = 0, kbog = 0;

  task automatic check(string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  function automatic int slots_of(int s);
    return (s < NC) ? 8 : 4;
  endfunction

  function automatic logic [5:0] id_of(int s, int k);
    if (s < NC) return {1'b0, 2'(s), 3'(k)};
    return {1'b1, 3'b000, 2'(k)};
  endfunction

  function automatic bit elig(int s);
    int tot, same, c; bit exa;
    tot = 0; same = 0; exa = 0;
    if (s < NC) begin
      if (!cv[s]) return 0;
      c = int'(ccat[s*3 +: 3]);
      for (int k = 0; k < 8; k++) if (rem[s][k] > 0) begin
        tot++;
        if (mcat[s][k] == c) same++;
        if (mex[s][k]) exa = 1;
      end
      if (c > 5 || tot >= 8) return 0;
      if (same >= ((c==0)?8:(c==1)?4:(c==2)?1:(c==3)?3:(c==4)?5:8)) return 0;
      if (cex[s] && exa) return 0;
      return 1;
    end
    if (!pv) return 0;
    for (int k = 0; k < 4; k++) if (rem[s][k] > 0) tot++;
    return tot < 4;
  endfunction

  function automatic int free_slot(int s);
    for (int k = 0; k < slots_of(s); k++) if (rem[s][k] == 0) return k;
    return 0;
  endfunction

  task automatic eval_cycle();
    int win, k, c;
    bit ev;
    logic [5:0] eid;
    int ecat;
    logic [NC-1:0] erdy;
    bit eprdy;
    erdy = '0; eprdy = 0; win = -1; eid = '0; ecat = 0;
    if (lock) begin
      ev = 1; eid = lock_id; ecat = 5;
    end else begin
      for (int i = 0; i < NS; i++) begin
        int j;
        j = (ptr + i) % NS;
        if (win < 0 && elig(j)) win = j;
      end
      ev = (win >= 0);
      if (ev) begin
        eid  = id_of(win, free_slot(win));
        ecat = (win < NC) ? int'(ccat[win*3 +: 3]) : 0;
        if (arr) begin
          if (win < NC) erdy[win] = 1'b1; else eprdy = 1;
        end
      end
    end
    check("ar_valid", int'(arv), int'(ev));
    check("ar_second (R8)", int'(arsec), int'(lock));
    check("core_ready (R7)", int'(crdy), int'(erdy));
    check("port_ready (R5)", int'(prdy), int'(eprdy));
    if (ev) begin
      check("ar_id (R4)", int'(arid), int'(eid));
      check("ar_cat", int'(arcat), ecat);
    end
    // state update
    if (lock) begin
      if (arr) lock = 0;
    end else if (ev && arr) begin
      k = free_slot(win);
      c = ecat;
      rem[win][k]  = (win < NC && c == 5 && ctwo[win]) ? 2 : 1;
      mcat[win][k] = c;
      mex[win][k]  = (win < NC) ? cex[win] : 1'b0;
      ptr = (win + 1) % NS;
      if (rem[win][k] == 2) begin lock = 1; lock_id = eid; end
    end
    if (rcv) begin
      int s, sl;
      s = -1; sl = 0;
      if (!rcid[5]) begin
        if (int'(rcid[4:3]) < NC) begin s = int'(rcid[4:3]); sl = int'(rcid[2:0]); end
      end else if (HP && rcid[4:2] == 3'b000) begin
        s = NC; sl = int'(rcid[1:0]);
      end
      if (s >= 0 && rem[s][sl] > 0) begin
        rem[s][sl]--;
        if (rem[s][sl] == 0) mex[s][sl] = 0;
      end
    end
  endtask

  task automatic drive();
    logic [5:0] q[$];
    for (int s = 0; s < NC; s++) begin
      int c;
      cv[s] = kmask[s] && ($urandom_range(99) < kreq);
      c = (kcat >= 0) ? kcat : (($urandom_range(9) == 0) ? 6 + $urandom_range(1) : $urandom_range(5));
      ccat[s*3 +: 3] = 3'(c);
      ctwo[s] = $urandom_range(99) < ktwo;
      cex[s]  = $urandom_range(99) < kex;
    end
    pv  = HP && kmask[NS-1] && ($urandom_range(99) < kreq);
    arr = $urandom_range(99) < krdy;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < slots_of(s); k++) if (rem[s][k] > 0) q.push_back(id_of(s, k));
    rcv = 0; rcid = '0;
    if ($urandom_range(99) < kbog) begin
      rcv = 1; rcid = 6'($urandom_range(63));
    end else if (q.size() > 0 && $urandom_range(99) < krc) begin
      rcv = 1; rcid = q[$urandom_range(q.size() - 1)];
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk_i); #1;
      drive();
      #1;
      eval_cycle();
    end
  endtask

  task automatic drain(int n);
    kmask = '0; krc = 100; kbog = 0; krdy = 100;
    tag = "R10";
    run(n);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) for (int k = 0; k < 8; k++) begin
      rem[s][k] = 0; mcat[s][k] = 0; mex[s][k] = 0;
    end
    // R1: idle outputs under reset and right after
    #12;
    tag = "R1";
    check("ar_valid in reset", int'(arv), 0);
    check("core_ready in reset", int'(crdy), 0);
    check("port_ready in reset", int'(prdy), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    run(3);

    // R2: fill core 0 with linefills, no completions
    tag = "R2"; kmask = 5'b00001; kcat = 0; krc = 0; kreq = 100; krdy = 100;
    run(14);
    drain(20);

    // R3: each category code on core 1, up to its cap
    for (int c = 0; c < 8; c++) begin
      tag = "R3"; kmask = 5'b00010; kcat = c; krc = 0; kreq = 100; krdy = 100;
      run(12);
      drain(14);
    end

    // R5: port fills its four slots
    tag = "R5"; kmask = 5'b10000; kcat = 0; krc = 0;
    run(10);
    drain(8);

    // R6: all sources compete
    tag = "R6"; kmask = 5'b11111; kcat = 0; krc = 30; krdy = 100; kreq = 90;
    run(60);

    // R7: ready withheld at random
    tag = "R7"; kcat = -1; krdy = 50; krc = 30;
    run(60);
    drain(30);

    // R8 then R9: two-part DVMs with stalls and split completions
    tag = "R8"; kmask = 5'b00100; kcat = 5; ktwo = 100; krdy = 60; krc = 0;
    run(12);
    tag = "R9"; krc = 50;
    run(40);
    drain(30);

    // R11: exclusive requests on core 3
    tag = "R11"; kmask = 5'b01000; kcat = -1; ktwo = 0; kex = 60; krc = 20; krdy = 100;
    run(60);

    // R10: completions for free slots and absent sources
    tag = "R10"; kmask = 5'b11111; kex = 20; kbog = 40; krc = 40; krdy = 80; ktwo = 30;
    run(100);

    // R4 and R12: long mixed run
    tag = "R4"; kbog = 10; krc = 35; krdy = 70; kreq = 70;
    run(600);
    drain(40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule